// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a management-port master for Clause 22 PHY access over a two-wire MDC/MDIO link. Software supplies one 32-bit maintenance word that is already the complete management frame: start pattern, opcode, PHY address, register address, turnaround and data. Once the word is accepted, the block sends 32 ones of preamble and then shifts the word out MSB first. For a read it releases the data line, samples the 16 bits the PHY returns and writes them into the low half of the same maintenance word. Reading that word back then yields the result.

MDC is produced from the block clock by a divider that a 3-bit select chooses. The divider ratio is latched when a frame starts, so changing the select has no effect on a frame already in progress. An idle flag tells software when a new word can be written. The command input is a plain write strobe with no back-pressure. The flag is the only form of flow control: a strobe seen while a frame is in progress is dropped, not held. A port-enable input gates the whole link. Clearing it aborts any frame and keeps the pins quiet.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: A frame is 32 cycles of MDC with MDIO driven to 1, followed by the 32 bits of the maintenance word MSB first. The word has the following layout: bits 31:30 start (01), bits 29:28 opcode, bits 27:23 PHY address, bits 22:18 register address, bits 17:16 turnaround (10), bits 15:0 data.
- R2: A pulse on `mnt_wr` while `idle` is 1 and `port_en` is 1 loads `mnt_wdata` into `mnt_word` and starts a frame. `idle` reads 0 from the next cycle on.
- R3: MDIO changes only when MDC falls (and when a frame starts). Each bit is held for one full MDC period, and MDC is low for the first half of that period.
- R4: `div_sel` sets the number of clock cycles per MDC period, and the value is latched at frame start. The values map as follows: 0 gives 8, 1 gives 16, 2 gives 32, 3 gives 48, 4 gives 64, 5 gives 96, 6 gives 128 and 7 gives 224. A frame has 65 rising edges of MDC.
- R5: Opcode 10 in bits 29:28 marks a read. The PHY bit is sampled at each MDC rising edge of the 16 data periods, first bit into bit 15. At frame end, the sampled bits replace `mnt_word[15:0]`. Bits 31:16 are unchanged. Any other opcode (01 = write) leaves `mnt_word` unchanged.
- R6: `mdio_oe` is 1 for every preamble and frame bit of a write. For a read, it is 0 for the two turnaround bits and the 16 data bits. It is 0 while idle and during the final MDC period.
- R7: A `mnt_wr` pulse while a frame is in progress is ignored. The register and the running frame are both unaffected.
- R8: After the last frame bit, one more MDC period runs with MDIO released. `idle` returns to 1 exactly 65 MDC periods after the frame started.
- R9: While `port_en` is 0, `mdc` and `mdio_oe` are 0. Clearing `port_en` during a frame aborts it: `idle` is 1 on the next cycle. A write while the port is disabled is ignored.
- R10: After reset, `idle` is 1, `mdc` is 0, `mdio_oe` is 0 and `mnt_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, source of MDC |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Management port enable |
| div_sel | input | 3 | MDC divider select |
| mnt_wr | input | 1 | Write strobe for the maintenance word |
| mnt_wdata | input | 32 | Maintenance word to write |
| mnt_word | output | 32 | Current maintenance word, read data in bits 15:0 after a read |
| idle | output | 1 | 1 when a new word can be accepted |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable, 1 = master drives |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The embedded assertions rely on a few facts about the inputs:
- `mdio_i` is stable around each MDC rising edge.
- `port_en` is not dropped in the same cycle as an accepted write.
- Frames are started only through the top-level accept gate, never by loading the shifter while it is busy.

The stimulus respects these facts. It drives the write strobe, the enable and the select a short time after a clock edge. The PHY model changes `mdio_i` only on the falling clock edge, and it drives the line to 1 outside the read data window. The abort scenario clears the enable well inside a frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_W = 32;
  localparam int DATA_W  = 16;
  localparam int HDR_W   = FRAME_W - DATA_W - 2;  // start, opcode, addresses
  localparam int DIV_W   = 8;
  localparam int SEL_W   = 3;
  localparam logic [1:0] OP_READ = 2'b10;

  function automatic logic [DIV_W-1:0] div_ratio(input logic [SEL_W-1:0] sel);
    logic [DIV_W-1:0] r;
    case (sel)
      3'd0:    r = 8'd8;
      3'd1:    r = 8'd16;
      3'd2:    r = 8'd32;
      3'd3:    r = 8'd48;
      3'd4:    r = 8'd64;
      3'd5:    r = 8'd96;
      3'd6:    r = 8'd128;
      default: r = 8'd224;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] ratio,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half, half_m1, last;

  assign half    = ratio >> 1;
  assign half_m1 = half - 1'b1;
  assign last    = ratio - 1'b1;

  assign rise_stb = run && (cnt == half_m1);
  assign fall_stb = run && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (fall_stb) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (rise_stb) mdc <= 1'b1;
    end
  end

  // R3: MDC stays low through the first half of each period
  a_r3_low_first_half: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt < half) |-> !mdc);
  // R4: MDC rises exactly at the midpoint count
  a_r4_rise_at_half: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $rose(mdc)) |-> (cnt == half));
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                abort,
  input  logic [FRAME_W-1:0]  word,
  input  logic                rise_stb,
  input  logic                fall_stb,
  input  logic                mdio_i,
  output logic                busy,
  output logic                is_read,
  output logic                finish,
  output logic                oe,
  output logic                bit_o,
  output logic [DATA_W-1:0]   rdata
);
  localparam int SH_W  = PRE_LEN + FRAME_W;
  localparam int K_W   = $clog2(SH_W + 1);
  localparam logic [K_W-1:0] K_TOTAL = K_W'(SH_W);
  localparam logic [K_W-1:0] K_TA    = K_W'(PRE_LEN + HDR_W);
  localparam logic [K_W-1:0] K_DATA  = K_W'(PRE_LEN + HDR_W + 2);

  logic [SH_W-1:0] sh;
  logic [K_W-1:0]  k;
  logic            in_data;

  assign in_data = (k >= K_DATA) && (k < K_TOTAL);
  assign finish  = busy && !abort && fall_stb && (k == K_TOTAL);
  assign oe      = busy && (k < K_TOTAL) && !(is_read && (k >= K_TA));
  assign bit_o   = sh[SH_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      k       <= '0;
      busy    <= 1'b0;
      is_read <= 1'b0;
      rdata   <= '0;
    end else if (load) begin
      sh      <= {{PRE_LEN{1'b1}}, word};
      k       <= '0;
      busy    <= 1'b1;
      is_read <= (word[FRAME_W-3:FRAME_W-4] == OP_READ);
    end else if (busy) begin
      if (abort) begin
        busy <= 1'b0;
      end else begin
        if (rise_stb && is_read && in_data)
          rdata <= {rdata[DATA_W-2:0], mdio_i};
        if (fall_stb) begin
          sh <= sh << 1;
          if (k == K_TOTAL) busy <= 1'b0;
          else              k <= k + 1'b1;
        end
      end
    end
  end

  // R3: the shift register moves only on an MDC falling edge
  a_r3_shift_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fall_stb && !load) |=> $stable(sh));
  // R6: once a read has released MDIO it stays released to frame end
  a_r6_release_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_read && !oe) |=> (!busy || !oe));
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               port_en,
  input  logic [SEL_W-1:0]   div_sel,
  input  logic               mnt_wr,
  input  logic [FRAME_W-1:0] mnt_wdata,
  output logic [FRAME_W-1:0] mnt_word,
  output logic               idle,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic               mdio_i
);
  logic              busy, finish, is_read, accept;
  logic              mdc_q, rise_stb, fall_stb, oe_raw, bit_raw;
  logic [DATA_W-1:0] rdata;
  logic [SEL_W-1:0]  div_q;
  logic [FRAME_W-1:0] word_q;

  assign accept = mnt_wr && port_en && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      div_q  <= '0;
    end else if (accept) begin
      word_q <= mnt_wdata;
      div_q  <= div_sel;
    end else if (finish && is_read) begin
      word_q[DATA_W-1:0] <= rdata;
    end
  end

  mdio_clkgen #(.CNT_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy && port_en),
    .ratio    (div_ratio(div_q)),
    .mdc      (mdc_q),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_shifter #(.PRE_LEN(PRE_LEN)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .abort    (!port_en),
    .word     (mnt_wdata),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .is_read  (is_read),
    .finish   (finish),
    .oe       (oe_raw),
    .bit_o    (bit_raw),
    .rdata    (rdata)
  );

  assign mnt_word = word_q;
  assign idle     = !busy;
  assign mdc      = mdc_q && port_en;
  assign mdio_oe  = oe_raw && port_en;
  assign mdio_o   = mdio_oe && bit_raw;

  // R2: a frame starts only from an enabled write
  a_r2_start_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(mnt_wr && port_en));
  // R7: a write during a frame leaves the register alone
  a_r7_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mnt_wr && !finish) |=> $stable(mnt_word));
  // R8: the port is idle right after the final period
  a_r8_idle_after_finish: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> idle);
  // R9: disabling the port ends a frame on the next cycle
  a_r9_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !port_en) |=> idle);
endmodule

// File: tb/mdio_frame_ctrl_test.sv
module mdio_frame_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_en = 1'b0;
  logic [2:0]  div_sel = 3'd0;
  logic        mnt_wr = 1'b0;
  logic [31:0] mnt_wdata = '0;
  logic [31:0] mnt_word;
  logic        idle, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  mdio_frame_ctrl uut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .div_sel(div_sel),
    .mnt_wr(mnt_wr), .mnt_wdata(mnt_wdata), .mnt_word(mnt_word),
    .idle(idle), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #5 clk = ~clk;

  // reference model state
  bit          m_busy = 0;
  bit          m_rd = 0;
  logic [31:0] m_word = '0;
  logic [15:0] m_cap = '0;
  logic [15:0] resp = 16'h0000;
  int          p = 0, k = 0, m_d = 8;
  int          busy_cycles = 0, mdc_rises = 0;
  bit          prev_mdc = 0;

  function automatic int ratio_of(input logic [2:0] s);
    int t[8] = '{8, 16, 32, 48, 64, 96, 128, 224};
    return t[s];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_word = '0;
    end else if (m_busy) begin
      if (!port_en) m_busy = 0;
      else begin
        if (p == m_d/2 - 1 && m_rd && k >= 48 && k < 64) m_cap[63-k] = mdio_i;
        if (p == m_d - 1) begin
          p = 0; k++;
          if (k == 65) begin
            m_busy = 0;
            if (m_rd) m_word[15:0] = m_cap;
          end
        end else p++;
      end
    end else if (mnt_wr && port_en) begin
      m_word = mnt_wdata; m_busy = 1; p = 0; k = 0;
      m_d = ratio_of(div_sel); m_rd = (mnt_wdata[29:28] == 2'b10);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit e_oe, e_mdc, e_bit;
      e_oe  = m_busy && port_en && k < 64 && !(m_rd && k >= 46);
      e_mdc = m_busy && port_en && p >= m_d/2;
      e_bit = e_oe && ((k < 32) ? 1'b1 : m_word[63-k]);
      check(mdc == e_mdc, "R4 mdc", 32'(mdc), 32'(e_mdc));
      check(mdio_oe == e_oe, "R6 mdio_oe", 32'(mdio_oe), 32'(e_oe));
      check(mdio_o == e_bit, "R1/R3 mdio_o", 32'(mdio_o), 32'(e_bit));
      check(idle == !m_busy, "R8 idle", 32'(idle), 32'(!m_busy));
      check(mnt_word == m_word, "R5 mnt_word", mnt_word, m_word);
      if (!idle) busy_cycles++;
      if (mdc && !prev_mdc) mdc_rises++;
      prev_mdc = mdc;
    end
    // PHY model: returns data in the read window, line pulled high otherwise
    mdio_i = (m_busy && m_rd && k >= 48 && k < 64) ? resp[63-k] : 1'b1;
  end

  function automatic logic [31:0] frame(input logic [1:0] op, input logic [4:0] phy,
                                        input logic [4:0] rg, input logic [15:0] d);
    return {2'b01, op, phy, rg, 2'b10, d};
  endfunction

  task automatic write_word(input logic [31:0] w);
    @(posedge clk); #2;
    mnt_wr = 1'b1; mnt_wdata = w;
    @(posedge clk); #2;
    mnt_wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (!idle) @(posedge clk);
    repeat (3) @(posedge clk);
    #2;
  endtask

  task automatic start_frame(input logic [2:0] sel, input logic [31:0] w);
    @(posedge clk); #2;
    div_sel = sel;
    busy_cycles = 0; mdc_rises = 0;
    write_word(w);
  endtask

  initial begin
    logic [31:0] w;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(idle == 1'b1, "R10 idle", 32'(idle), 1);
    check(mdc == 1'b0, "R10 mdc", 32'(mdc), 0);
    check(mdio_oe == 1'b0, "R10 mdio_oe", 32'(mdio_oe), 0);
    check(mnt_word == 32'h0, "R10 mnt_word", mnt_word, 0);

    #2 port_en = 1'b1;

    // write frame, ratio 8
    w = frame(2'b01, 5'd5, 5'd3, 16'h1234);
    start_frame(3'd0, w);
    @(negedge clk);
    check(idle == 1'b0, "R2 idle after write", 32'(idle), 0);
    wait_idle();
    check(mnt_word == w, "R5 write keeps word", mnt_word, w);
    check(busy_cycles == 65*8, "R8 busy length sel0", busy_cycles, 65*8);
    check(mdc_rises == 65, "R4 rises sel0", mdc_rises, 65);

    // read frame, ratio 16, with a write while busy
    resp = 16'hA5C3;
    w = frame(2'b10, 5'd31, 5'd1, 16'hFFFF);
    start_frame(3'd1, w);
    repeat (100) @(posedge clk);
    write_word(32'h5000_0000);
    @(negedge clk);
    check(mnt_word == w, "R7 busy write ignored", mnt_word, w);
    wait_idle();
    check(mnt_word == {w[31:16], 16'hA5C3}, "R5 read data", mnt_word, {w[31:16], 16'hA5C3});
    check(mdc_rises == 65, "R4 rises sel1", mdc_rises, 65);
    check(busy_cycles == 65*16, "R8 busy length sel1", busy_cycles, 65*16);

    // read frame, ratio 32
    resp = 16'h0F0F;
    w = frame(2'b10, 5'd0, 5'd2, 16'h0000);
    start_frame(3'd2, w);
    #30 div_sel = 3'd0;  // R4: change after start has no effect
    wait_idle();
    check(busy_cycles == 65*32, "R4 busy length sel2", busy_cycles, 65*32);
    check(mnt_word[15:0] == 16'h0F0F, "R5 read data 2", 32'(mnt_word[15:0]), 32'h0F0F);

    // write frame, ratio 48
    w = frame(2'b01, 5'd12, 5'd30, 16'h8001);
    start_frame(3'd3, w);
    wait_idle();
    check(busy_cycles == 65*48, "R4 busy length sel3", busy_cycles, 65*48);
    check(mnt_word == w, "R5 write keeps word 2", mnt_word, w);

    // R9: abort by clearing enable
    w = frame(2'b01, 5'd1, 5'd4, 16'hBEEF);
    start_frame(3'd0, w);
    repeat (50) @(posedge clk);
    #2 port_en = 1'b0;
    @(negedge clk);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R9 quiet when disabled", {mdc, mdio_oe}, 0);
    @(negedge clk);
    check(idle == 1'b1, "R9 idle after abort", 32'(idle), 1);
    write_word(32'h6000_0000);
    repeat (4) @(negedge clk);
    check(idle == 1'b1, "R9 write while disabled", 32'(idle), 1);
    check(mnt_word == w, "R9 word unchanged", mnt_word, w);
    #2 port_en = 1'b1;

    // R6/R1: short read after re-enable
    resp = 16'h8000;
    start_frame(3'd0, frame(2'b10, 5'd9, 5'd9, 16'h0000));
    wait_idle();
    check(mnt_word[15:0] == 16'h8000, "R5 msb first", 32'(mnt_word[15:0]), 32'h8000);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule